// File: doc/BRIEF.md
# Serial Output Expander Controller

The block turns a 24-bit output image into a serial stream for a chain of up to three external 8-bit shift-and-latch devices. It drives a data line and a shift clock. After the last bit it raises a store strobe so that every external device moves its shifted contents to its parallel outputs at the same moment. Software writes the image and the settings through a simple write-strobe register port. A frame starts by itself whenever the effective image differs from the one last sent.

Each 8-bit group can be enabled or skipped. A skipped group gets no clock pulses, so the chain can be shorter than three devices. The lowest eight output bits can be taken, bit by bit, from three hardware status inputs instead of from the software image. A 2-bit source owns bits 0 and 1, a first 3-bit source owns bits 2 to 4, and a second 3-bit source owns bits 5 to 7. A setting picks whether the external devices sample on the rising or the falling edge of the shift clock.

Top module: `cascade_out_ctrl`

## Requirements
- R1: After reset the software image equals parameter RESET_IMAGE, all groups are enabled, falling-edge sampling is selected and no override is enabled. No frame is sent until the effective image changes. The shift clock rests high, and busy and the store strobe are low.
- R2: A frame sends the enabled groups from the highest-numbered group down. Within a group it sends bit 7 first and bit 0 last, so that image bit 0 is the last bit clocked in.
- R3: Group g covers image bits 8g+7..8g, and mask bit g enables it. A disabled group is left out of the frame. With an empty mask a frame has no shift clock pulses and still has its store strobe.
- R4: Override enable bit k (k = 0, 1) replaces image bit k with bit k of the 2-bit status input. A clear enable bit leaves the software bit in place.
- R5: Override enable bits 2 to 4 replace image bits 2 to 4 with bits 0 to 2 of the first 3-bit status input, each bit on its own.
- R6: Override enable bits 5 to 7 replace image bits 5 to 7 with bits 0 to 2 of the second 3-bit status input, each bit on its own.
- R7: Each bit occupies 2*HALF_PERIOD system clocks. The data line changes at the start of the slot, and the sampling edge comes HALF_PERIOD clocks later. Edge setting 1 selects rising-edge sampling, with the clock resting low. Edge setting 0 selects falling-edge sampling, with the clock resting high.
- R8: After the last bit the store strobe is high for exactly 2*HALF_PERIOD clocks, with no shift clock edge in that time.
- R9: Busy is high from the cycle after a frame starts until the store strobe ends. For n enabled groups that is 8*n*2*HALF_PERIOD + 2*HALF_PERIOD clocks.
- R10: A frame starts only when the effective image (software image after the overrides) differs from the last image sent. Writing the mask or the edge setting alone, or rewriting the same image, sends nothing.
- R11: Writes made during a frame do not alter it. If they change the effective image, a second frame carries the new value once the first ends.
- R12: Register addresses: 0 holds the image, bits 23..0. 1 holds the group mask, bits 2..0. 2 holds the edge setting, bit 0. 3 holds the override enables, bits 7..0, where bit k governs image bit k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address |
| wrData | input | GROUPS*GROUP_W | Register write data |
| dslStat | input | DSL_W | 2-bit hardware status source for bits 0..1 |
| phyAStat | input | PHYA_W | First 3-bit hardware status source for bits 2..4 |
| phyBStat | input | PHYB_W | Second 3-bit hardware status source for bits 5..7 |
| serData | output | 1 | Serial data to the chain |
| serClk | output | 1 | Shift clock to the chain |
| storeStrobe | output | 1 | Parallel-update strobe to the chain |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with HALF_PERIOD = 2, so a 24-bit frame plus its store strobe lasts exactly 100 clocks. That short frame lets every mask pattern, every override source, both edge settings and a write made in the middle of a frame run within a small cycle budget. The bench also sets RESET_IMAGE to 24'h00077F, a non-zero value. An override can then expose that reset image through a real frame, and the bench can confirm that no frame is sent when the reset ends.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

  // Width of the frame bit position carried from control to datapath.
  localparam int unsigned POS_W = 8;

  // Register addresses.
  localparam logic [1:0] ADDR_IMAGE = 2'd0;
  localparam logic [1:0] ADDR_MASK  = 2'd1;
  localparam logic [1:0] ADDR_EDGE  = 2'd2;
  localparam logic [1:0] ADDR_OVR   = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_STORE = 2'd2
  } frameState_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic             load;      // capture the effective image, frame begins
    logic             active;    // frame in progress
    logic             shifting;  // bit slots running
    logic [POS_W-1:0] bitPos;    // image bit on the data line
  } ctrlStrobe_t;

endpackage

// File: rtl/sipo_datapath.sv
module sipo_datapath
  import sipo_pkg::*;
#(
  parameter int unsigned GROUPS  = 3,
  parameter int unsigned GROUP_W = 8,
  parameter int unsigned DSL_W   = 2,
  parameter int unsigned PHYA_W  = 3,
  parameter int unsigned PHYB_W  = 3,
  parameter logic [GROUPS*GROUP_W-1:0] RESET_IMAGE = '0,
  parameter logic [GROUPS-1:0]         RESET_MASK  = '1,
  localparam int unsigned IMG_W = GROUPS * GROUP_W,
  localparam int unsigned OVR_W = DSL_W + PHYA_W + PHYB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [IMG_W-1:0]  wrData,
  input  logic [DSL_W-1:0]  dslStat,
  input  logic [PHYA_W-1:0] phyAStat,
  input  logic [PHYB_W-1:0] phyBStat,
  input  ctrlStrobe_t       ctrl,
  output logic              frameReq,
  output logic [GROUPS-1:0] liveMask,
  output logic              liveRising,
  output logic              serData
);

  logic [IMG_W-1:0] swImage;
  logic [IMG_W-1:0] effImg;
  logic [IMG_W-1:0] lastSent;
  logic [IMG_W-1:0] frameImg;
  logic [OVR_W-1:0] ovrEn;
  logic [OVR_W-1:0] hwVec;

  // The three sources sit next to each other from bit 0 upward.
  assign hwVec = {phyBStat, phyAStat, dslStat};

  // Register port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      swImage    <= RESET_IMAGE;
      liveMask   <= RESET_MASK;
      liveRising <= 1'b0;
      ovrEn      <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_IMAGE: swImage    <= wrData;
        ADDR_MASK:  liveMask   <= wrData[GROUPS-1:0];
        ADDR_EDGE:  liveRising <= wrData[0];
        ADDR_OVR:   ovrEn      <= wrData[OVR_W-1:0];
        default:    ;
      endcase
    end
  end

  // Bitwise override mux, one lane per overridable bit
  for (genvar k = 0; k < IMG_W; k++) begin : g_lane
    if (k < OVR_W) begin : g_ovr
      assign effImg[k] = ovrEn[k] ? hwVec[k] : swImage[k];
    end else begin : g_sw
      assign effImg[k] = swImage[k];
    end
  end

  assign frameReq = (effImg != lastSent);

  // Frame snapshot and last-sent record
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastSent <= RESET_IMAGE;
      frameImg <= RESET_IMAGE;
    end else if (ctrl.load) begin
      lastSent <= effImg;
      frameImg <= effImg;
    end
  end

  // Serial bit select
  always_comb begin
    serData = 1'b0;
    if (ctrl.shifting) begin
      for (int k = 0; k < IMG_W; k++) begin
        if (ctrl.bitPos == POS_W'(k)) serData = frameImg[k];
      end
    end
  end

  AST_DATA_HOLDS_IN_SLOT: assert property (@(posedge clk) disable iff (!rstN) ctrl.shifting && $past(ctrl.shifting) && $stable(ctrl.bitPos) |-> $stable(serData)); // R7
  AST_FRAME_FROZEN: assert property (@(posedge clk) disable iff (!rstN) ctrl.active && $past(ctrl.active) |-> $stable(frameImg)); // R11
  AST_REQ_CLEARS_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN) ctrl.load && !(wrEn && wrAddr == ADDR_IMAGE) && !(wrEn && wrAddr == ADDR_OVR) && $stable(hwVec) |=> $stable(hwVec) -> !frameReq); // R10

endmodule

// File: rtl/sipo_control.sv
module sipo_control
  import sipo_pkg::*;
#(
  parameter int unsigned GROUPS      = 3,
  parameter int unsigned GROUP_W     = 8,
  parameter int unsigned HALF_PERIOD = 4,
  localparam int unsigned GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int unsigned BIT_W = (GROUP_W > 1) ? $clog2(GROUP_W) : 1,
  localparam int unsigned SLOT  = 2 * HALF_PERIOD,
  localparam int unsigned PH_W  = (SLOT > 1) ? $clog2(SLOT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameReq,
  input  logic [GROUPS-1:0] liveMask,
  input  logic              liveRising,
  output ctrlStrobe_t       ctrl,
  output logic              serClk,
  output logic              storeStrobe,
  output logic              busy
);

  frameState_t       state;
  logic [PH_W-1:0]   phase;
  logic [BIT_W-1:0]  bitIdx;
  logic [GRP_W-1:0]  grp;
  logic [GROUPS-1:0] maskSnap;
  logic              risingSnap;
  logic              phaseLast;
  logic [GRP_W:0]    firstPick;
  logic [GRP_W:0]    nextPick;
  logic              idleLvl;

  // Highest enabled group below lim: {found, index}
  function automatic logic [GRP_W:0] pickGroup(input logic [GROUPS-1:0] m, input int lim);
    logic [GRP_W:0] r;
    r = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (m[g] && g < lim) r = {1'b1, GRP_W'(g)};
    end
    return r;
  endfunction

  assign phaseLast = (phase == PH_W'(SLOT - 1));
  assign firstPick = pickGroup(liveMask, GROUPS);
  assign nextPick  = pickGroup(maskSnap, int'(grp));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phase      <= '0;
      bitIdx     <= '0;
      grp        <= '0;
      maskSnap   <= '0;
      risingSnap <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (frameReq) begin
            maskSnap   <= liveMask;
            risingSnap <= liveRising;
            phase      <= '0;
            bitIdx     <= BIT_W'(GROUP_W - 1);
            grp        <= firstPick[GRP_W-1:0];
            state      <= firstPick[GRP_W] ? ST_SHIFT : ST_STORE;
          end
        end
        ST_SHIFT: begin
          phase <= phaseLast ? '0 : phase + 1'b1;
          if (phaseLast) begin
            if (bitIdx == '0) begin
              if (nextPick[GRP_W]) begin
                grp    <= nextPick[GRP_W-1:0];
                bitIdx <= BIT_W'(GROUP_W - 1);
              end else begin
                state <= ST_STORE;
              end
            end else begin
              bitIdx <= bitIdx - 1'b1;
            end
          end
        end
        ST_STORE: begin
          phase <= phaseLast ? '0 : phase + 1'b1;
          if (phaseLast) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign storeStrobe = (state == ST_STORE);
  assign idleLvl     = (state == ST_IDLE) ? ~liveRising : ~risingSnap;
  assign serClk      = (state == ST_SHIFT && phase >= PH_W'(HALF_PERIOD)) ? ~idleLvl : idleLvl;

  always_comb begin
    ctrl.load     = (state == ST_IDLE) && frameReq;
    ctrl.active   = busy;
    ctrl.shifting = (state == ST_SHIFT);
    ctrl.bitPos   = POS_W'(grp) * POS_W'(GROUP_W) + POS_W'(bitIdx);
  end

  // Count of sampling edges in the current frame, used by the checks below.
  logic [POS_W-1:0] edgeCnt;
  always_ff @(posedge clk) begin
    if (!rstN) edgeCnt <= '0;
    else if (ctrl.load) edgeCnt <= '0;
    else if (state == ST_SHIFT && phase == PH_W'(HALF_PERIOD)) edgeCnt <= edgeCnt + 1'b1;
  end

  AST_STORE_CLK_QUIET: assert property (@(posedge clk) disable iff (!rstN) storeStrobe && $past(storeStrobe) |-> $stable(serClk)); // R8
  AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rstN) $rose(storeStrobe) |-> int'(edgeCnt) == GROUP_W * $countones(maskSnap)); // R3
  AST_REQ_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rstN) frameReq && !busy |=> busy); // R10
  AST_STORE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> $past(storeStrobe)); // R9

endmodule

// File: rtl/cascade_out_ctrl.sv
module cascade_out_ctrl
  import sipo_pkg::*;
#(
  parameter int unsigned GROUPS      = 3,
  parameter int unsigned GROUP_W     = 8,
  parameter int unsigned HALF_PERIOD = 4,
  parameter int unsigned DSL_W       = 2,
  parameter int unsigned PHYA_W      = 3,
  parameter int unsigned PHYB_W      = 3,
  parameter logic [GROUPS*GROUP_W-1:0] RESET_IMAGE = '0,
  parameter logic [GROUPS-1:0]         RESET_MASK  = '1,
  localparam int unsigned IMG_W = GROUPS * GROUP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [IMG_W-1:0]  wrData,
  input  logic [DSL_W-1:0]  dslStat,
  input  logic [PHYA_W-1:0] phyAStat,
  input  logic [PHYB_W-1:0] phyBStat,
  output logic              serData,
  output logic              serClk,
  output logic              storeStrobe,
  output logic              busy
);

  ctrlStrobe_t       ctrl;
  logic              frameReq;
  logic [GROUPS-1:0] liveMask;
  logic              liveRising;

  sipo_datapath #(
    .GROUPS(GROUPS), .GROUP_W(GROUP_W),
    .DSL_W(DSL_W), .PHYA_W(PHYA_W), .PHYB_W(PHYB_W),
    .RESET_IMAGE(RESET_IMAGE), .RESET_MASK(RESET_MASK)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .dslStat(dslStat), .phyAStat(phyAStat), .phyBStat(phyBStat),
    .ctrl(ctrl), .frameReq(frameReq), .liveMask(liveMask),
    .liveRising(liveRising), .serData(serData)
  );

  sipo_control #(
    .GROUPS(GROUPS), .GROUP_W(GROUP_W), .HALF_PERIOD(HALF_PERIOD)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .frameReq(frameReq), .liveMask(liveMask), .liveRising(liveRising),
    .ctrl(ctrl), .serClk(serClk), .storeStrobe(storeStrobe), .busy(busy)
  );

endmodule

// File: tb/sim_cascade_out_ctrl.sv
`timescale 1ns/1ps
module sim_cascade_out_ctrl;

  localparam int HALF = 2;
  localparam logic [23:0] RST_IMG = 24'h00077F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [23:0] wrData = '0;
  logic [1:0] dslStat = '0;
  logic [2:0] phyAStat = '0;
  logic [2:0] phyBStat = '0;
  logic serData, serClk, storeStrobe, busy;

  always #5 clk = ~clk;

  cascade_out_ctrl #(.HALF_PERIOD(HALF), .RESET_IMAGE(RST_IMG)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .dslStat(dslStat), .phyAStat(phyAStat), .phyBStat(phyBStat),
    .serData(serData), .serClk(serClk), .storeStrobe(storeStrobe), .busy(busy)
  );

  int compared = 0;
  int mismatched = 0;

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Chain model: collect bits on sampling edges, log frames on the store strobe
  logic        benchRising = 1'b0;
  logic [47:0] cap = '0;
  int capBits = 0;
  int frameCount = 0;
  logic [23:0] frameLog [8];
  int bitLog [8];
  int negCnt = 0, lastEdgeT = 0, lastDataT = 0;
  int badPeriod = 0, badSetup = 0;
  int storeRun = 0, lastStoreLen = 0, busyRun = 0, lastBusyLen = 0;
  logic prevClk = 1'b1, prevStore = 1'b0, prevBusy = 1'b0, prevData = 1'b0;

  always @(negedge clk) begin
    negCnt++;
    if (serData !== prevData) lastDataT = negCnt;
    if (busy && serClk !== prevClk && serClk === benchRising) begin
      if (capBits > 0 && negCnt - lastEdgeT != 2*HALF) badPeriod++;
      if (negCnt - lastDataT < HALF) badSetup++;
      lastEdgeT = negCnt;
      cap = {cap[46:0], serData};
      capBits++;
    end
    if (storeStrobe && !prevStore) begin
      frameLog[frameCount % 8] = cap[23:0];
      bitLog[frameCount % 8] = capBits;
      frameCount++;
      cap = '0;
      capBits = 0;
      storeRun = 0;
    end
    if (storeStrobe) storeRun++;
    if (!storeStrobe && prevStore) lastStoreLen = storeRun;
    if (busy) busyRun++;
    if (!busy && prevBusy) begin
      lastBusyLen = busyRun;
      busyRun = 0;
    end
    prevClk = serClk; prevStore = storeStrobe; prevBusy = busy; prevData = serData;
  end

  task automatic regWrite(input logic [1:0] a, input logic [23:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    int quiet = 0;
    while (quiet < 20) begin
      @(posedge clk); #2;
      if (busy) quiet = 0; else quiet++;
    end
  endtask

  typedef struct packed {
    logic [23:0] img;
    logic [2:0]  mask;
    logic [7:0]  ovr;
    logic [1:0]  dsl;
    logic [2:0]  pa;
    logic [2:0]  pb;
    logic [23:0] expFrame;
    logic [5:0]  expBits;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{24'hA5C3F0, 3'b111, 8'h00, 2'b00, 3'b000, 3'b000, 24'hA5C3F0, 6'd24}, // R2 full order
    '{24'h123456, 3'b001, 8'h00, 2'b00, 3'b000, 3'b000, 24'h000056, 6'd8},  // R3 group 0 only
    '{24'h123457, 3'b101, 8'h00, 2'b00, 3'b000, 3'b000, 24'h001257, 6'd16}, // R3 group 1 skipped
    '{24'h00FF00, 3'b010, 8'h00, 2'b00, 3'b000, 3'b000, 24'h0000FF, 6'd8},  // R3 middle group
    '{24'h000000, 3'b111, 8'hFF, 2'b11, 3'b101, 3'b011, 24'h000077, 6'd24}, // R4 R5 R6 all sources
    '{24'hFFFFFF, 3'b111, 8'h03, 2'b00, 3'b000, 3'b000, 24'hFFFFFC, 6'd24}, // R4 low pair
    '{24'hFFFFFF, 3'b111, 8'h1C, 2'b00, 3'b010, 3'b000, 24'hFFFFEB, 6'd24}, // R5
    '{24'h000000, 3'b111, 8'hA1, 2'b11, 3'b111, 3'b111, 24'h0000A1, 6'd24}  // R6 partial enables
  };

  logic done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (50) @(posedge clk);
    #2;
    // R1: reset state at the ports
    checkVal("R1 no frame after reset", frameCount, 0);
    checkVal("R1 clock rests high", serClk, 1);
    checkVal("R1 busy low", busy, 0);
    checkVal("R1 store low", storeStrobe, 0);

    // R1: expose reset image through one override bit
    dslStat = 2'b00;
    regWrite(2'd3, 24'h000001);
    waitIdle();
    checkVal("R1 reset image", frameLog[(frameCount-1) % 8], 24'h00077E);
    checkVal("R1 all groups enabled", bitLog[(frameCount-1) % 8], 24);
    regWrite(2'd3, 24'h000000);
    waitIdle();

    // Table walk: R2 R3 R4 R5 R6 R12
    for (int i = 0; i < 8; i++) begin
      regWrite(2'd1, {21'd0, VECS[i].mask});
      dslStat = VECS[i].dsl; phyAStat = VECS[i].pa; phyBStat = VECS[i].pb;
      regWrite(2'd3, {16'd0, VECS[i].ovr});
      regWrite(2'd0, VECS[i].img);
      waitIdle();
      checkVal($sformatf("R12 row %0d frame", i), frameLog[(frameCount-1) % 8], VECS[i].expFrame);
      checkVal($sformatf("R3 row %0d bit count", i), bitLog[(frameCount-1) % 8], 32'(VECS[i].expBits));
    end
    regWrite(2'd3, 24'h000000);
    waitIdle();

    // R8 R9: full frame timing
    regWrite(2'd1, 24'h000007);
    regWrite(2'd0, 24'h5A5A5A);
    waitIdle();
    checkVal("R2 frame 5A5A5A", frameLog[(frameCount-1) % 8], 24'h5A5A5A);
    checkVal("R9 busy length", lastBusyLen, 24*2*HALF + 2*HALF);
    checkVal("R8 store length", lastStoreLen, 2*HALF);

    // R11: write during a frame is held for the next frame
    base = frameCount;
    regWrite(2'd0, 24'h111111);
    while (!busy) @(posedge clk);
    repeat (10) @(posedge clk);
    regWrite(2'd0, 24'h222222);
    waitIdle();
    checkVal("R11 two frames", frameCount - base, 2);
    checkVal("R11 first frame", frameLog[base % 8], 24'h111111);
    checkVal("R11 second frame", frameLog[(base+1) % 8], 24'h222222);

    // R10: mask write and same-image write start nothing
    base = frameCount;
    regWrite(2'd1, 24'h000003);
    regWrite(2'd0, 24'h222222);
    regWrite(2'd2, 24'h000000);
    waitIdle();
    checkVal("R10 no frame", frameCount - base, 0);

    // R7: rising-edge sampling
    benchRising = 1'b1;
    regWrite(2'd2, 24'h000001);
    repeat (3) @(posedge clk); #2;
    checkVal("R7 clock rests low", serClk, 0);
    regWrite(2'd0, 24'h0F0F0F);
    waitIdle();
    checkVal("R7 rising frame", frameLog[(frameCount-1) % 8], 24'h000F0F);
    checkVal("R7 rising bit count", bitLog[(frameCount-1) % 8], 16);
    checkVal("R7 slot period", badPeriod, 0);
    checkVal("R7 data lead", badSetup, 0);

    // R3: empty mask still strobes
    base = frameCount;
    regWrite(2'd1, 24'h000000);
    regWrite(2'd0, 24'h333333);
    waitIdle();
    checkVal("R3 empty mask frame", frameCount - base, 1);
    checkVal("R3 empty mask bits", bitLog[base % 8], 0);
    checkVal("R8 empty mask store", lastStoreLen, 2*HALF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule